// File: doc/BRIEF.md
# Activate-to-Column Delay Checker

This block is a passive monitor that watches a decoded stream of DRAM commands. For every bank of every rank it remembers whether a row was opened and how many clock cycles have passed since that ACTIVATE. When a READ or WRITE reaches a bank that is open, it compares the elapsed cycles against the minimum activate-to-column spacing. It raises a one-cycle violation flag when the command arrived too early, and reports the rank, the bank and the measured distance.

The limit is not a fixed row-to-column figure. Additive latency delays the internal column access, so the checked minimum is the programmed row-to-column delay minus the programmed additive latency. The result is clamped to zero when the additive latency is as large as or larger than the delay. Both values are given in clock cycles. A PRECHARGE closes the bank, and column commands to a closed bank are not judged.

Top module: `act_col_checker`

## Requirements
- R1: While reset is asserted and after it is released, `viol_o` is low and every bank is closed, so a READ or WRITE issued before any ACTIVATE raises no violation.
- R2: Command codes on `cmd_i` are 0 idle, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE. Codes 5 to 7 are ignored and neither open, close nor check a bank.
- R3: A READ or WRITE to an open bank whose distance from its ACTIVATE (in command cycles, where back-to-back is 1) is below the effective limit drives `viol_o` high for one cycle, in the cycle after the command is sampled.
- R4: A READ or WRITE at a distance equal to or greater than the effective limit raises no violation. Meeting the limit exactly is legal.
- R5: The effective limit is `trcd_i - al_i` when `trcd_i > al_i`. A configuration change takes effect for commands sampled two or more cycles later.
- R6: When `al_i >= trcd_i` the effective limit is zero and no column command is ever flagged.
- R7: While `viol_o` is high, `viol_rank_o`, `viol_bank_o` and `viol_dist_o` give the rank, bank and distance of the offending command.
- R8: A PRECHARGE to a bank closes it. A later READ or WRITE to it is not checked until it is activated again.
- R9: Banks are tracked independently. An ACTIVATE or PRECHARGE to one rank and bank leaves the timing of every other bank unchanged.
- R10: An ACTIVATE to a bank that is already open restarts its distance from that ACTIVATE.
- R11: The distance counter of a bank saturates at 2^AGE_W-1 and does not wrap, so a long-open bank is never flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Decoded command code |
| rank_i | input | RANK_W | Rank addressed by the command |
| bank_i | input | BANK_W | Bank addressed by the command |
| trcd_i | input | LIM_W | Row-to-column delay in cycles |
| al_i | input | LIM_W | Additive latency in cycles |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_rank_o | output | RANK_W | Rank of the offending command |
| viol_bank_o | output | BANK_W | Bank of the offending command |
| viol_dist_o | output | AGE_W | Measured ACTIVATE-to-column distance |

## Verification
Two functions can land on the same cycle for one bank: re-arming its distance counter on a new ACTIVATE, and the counter's own increment or hold at saturation. The bench provokes this by leaving a bank open well past saturation, then activating it again and following with a READ two cycles later. The READ must be flagged with distance 2, not passed as a saturated bank. Around this, a sweep over several delay and latency pairs crosses every distance from 1 to 14. The bench judges each command against a model that takes the clamped difference and compares it with the distance counted in its own cycle counter.

// File: rtl/act_col_pkg.sv
package act_col_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4
  } dram_cmd_e;

  function automatic logic is_column(input logic [2:0] code);
    return (code == CMD_RD) || (code == CMD_WR);
  endfunction

endpackage

// File: rtl/act_col_limit.sv
module act_col_limit #(
  parameter int LIM_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LIM_W-1:0] trcd_i,
  input  logic [LIM_W-1:0] al_i,
  output logic [LIM_W-1:0] lim_o
);

  logic [LIM_W-1:0] lim_d;
  logic [LIM_W-1:0] lim_q;

  // Effective minimum spacing, clamped at zero.
  always_comb begin
    if (trcd_i > al_i) lim_d = trcd_i - al_i;
    else               lim_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lim_q <= '0;
    else        lim_q <= lim_d;
  end

  assign lim_o = lim_q;

  assert_clamp_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (al_i >= trcd_i) |=> (lim_o == '0));

  assert_limit_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trcd_i > al_i) |=> (lim_o + $past(al_i) == $past(trcd_i)));

endmodule

// File: rtl/act_col_bank.sv
module act_col_bank #(
  parameter int AGE_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             pre_i,
  output logic             open_o,
  output logic [AGE_W-1:0] age_o
);

  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};
  localparam logic [AGE_W-1:0] AGE_ONE = AGE_W'(1);

  logic             open_d, open_q;
  logic [AGE_W-1:0] age_d,  age_q;
  logic             age_en;

  always_comb begin
    open_d = open_q;
    if (act_i)      open_d = 1'b1;
    else if (pre_i) open_d = 1'b0;
  end

  // Counter runs only while the bank is open and not yet saturated.
  always_comb begin
    age_en = act_i || (open_q && (age_q != AGE_MAX));
    if (act_i) age_d = AGE_ONE;
    else       age_d = age_q + AGE_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      age_q  <= '0;
    end else begin
      open_q <= open_d;
      if (age_en) age_q <= age_d;
    end
  end

  assign open_o = open_q;
  assign age_o  = age_q;

  assert_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> (open_o && (age_o == AGE_ONE)));

  assert_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_i && !act_i) |=> !open_o);

  assert_saturate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_i && (age_o == AGE_MAX)) |=> (age_o == AGE_MAX));

endmodule

// File: rtl/act_col_report.sv
module act_col_report #(
  parameter int NUM    = 16,
  parameter int IDX_W  = 4,
  parameter int AGE_W  = 7,
  parameter int LIM_W  = 6,
  parameter int RANK_W = 1,
  parameter int BANK_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 col_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [RANK_W-1:0]    rank_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic [NUM-1:0]       open_vec_i,
  input  logic [NUM*AGE_W-1:0] age_flat_i,
  input  logic [LIM_W-1:0]     lim_i,
  output logic                 viol_o,
  output logic [RANK_W-1:0]    viol_rank_o,
  output logic [BANK_W-1:0]    viol_bank_o,
  output logic [AGE_W-1:0]     viol_dist_o
);

  logic             sel_open;
  logic [AGE_W-1:0] sel_age;
  logic [AGE_W-1:0] lim_ext;
  logic             hit;

  logic             viol_q;
  logic [RANK_W-1:0] rank_q;
  logic [BANK_W-1:0] bank_q;
  logic [AGE_W-1:0]  dist_q;

  always_comb begin
    sel_open = open_vec_i[idx_i];
    sel_age  = age_flat_i[idx_i*AGE_W +: AGE_W];
    lim_ext  = {{(AGE_W-LIM_W){1'b0}}, lim_i};
    hit      = col_i && sel_open && (sel_age < lim_ext);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q <= 1'b0;
      rank_q <= '0;
      bank_q <= '0;
      dist_q <= '0;
    end else begin
      viol_q <= hit;
      if (hit) begin
        rank_q <= rank_i;
        bank_q <= bank_i;
        dist_q <= sel_age;
      end
    end
  end

  assign viol_o      = viol_q;
  assign viol_rank_o = rank_q;
  assign viol_bank_o = bank_q;
  assign viol_dist_o = dist_q;

  assert_below_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> (viol_dist_o < {{(AGE_W-LIM_W){1'b0}}, $past(lim_i)}));

  assert_from_column_R3: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> ($past(col_i) && $past(sel_open)));

  assert_zero_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lim_i) == '0) |-> !viol_o);

  assert_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> ((viol_rank_o == $past(rank_i)) && (viol_bank_o == $past(bank_i))));

endmodule

// File: rtl/act_col_checker.sv
module act_col_checker #(
  parameter int RANKS  = 2,
  parameter int BANKS  = 8,
  parameter int LIM_W  = 6,
  parameter int AGE_W  = 7,
  parameter int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
  parameter int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_i,
  input  logic [RANK_W-1:0] rank_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [LIM_W-1:0]  trcd_i,
  input  logic [LIM_W-1:0]  al_i,
  output logic              viol_o,
  output logic [RANK_W-1:0] viol_rank_o,
  output logic [BANK_W-1:0] viol_bank_o,
  output logic [AGE_W-1:0]  viol_dist_o
);
  import act_col_pkg::*;

  localparam int NUM   = RANKS * BANKS;
  localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1;

  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic                 is_act, is_pre, is_col, addr_ok;
  logic [IDX_W-1:0]     idx;
  logic [NUM-1:0]       open_vec;
  logic [NUM*AGE_W-1:0] age_flat;
  logic [LIM_W-1:0]     lim;

  // Reset asserts at once, releases two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    addr_ok = (int'(rank_i) < RANKS) && (int'(bank_i) < BANKS);
    is_act  = addr_ok && (cmd_i == CMD_ACT);
    is_pre  = addr_ok && (cmd_i == CMD_PRE);
    is_col  = addr_ok && is_column(cmd_i);
    idx     = IDX_W'(int'(rank_i) * BANKS + int'(bank_i));
  end

  act_col_limit #(.LIM_W(LIM_W)) u_limit (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .trcd_i (trcd_i),
    .al_i   (al_i),
    .lim_o  (lim)
  );

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      localparam int K = r * BANKS + b;
      logic sel;
      assign sel = (rank_i == RANK_W'(r)) && (bank_i == BANK_W'(b));

      act_col_bank #(.AGE_W(AGE_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_int_n),
        .act_i  (is_act && sel),
        .pre_i  (is_pre && sel),
        .open_o (open_vec[K]),
        .age_o  (age_flat[K*AGE_W +: AGE_W])
      );
    end
  end

  act_col_report #(
    .NUM(NUM), .IDX_W(IDX_W), .AGE_W(AGE_W), .LIM_W(LIM_W),
    .RANK_W(RANK_W), .BANK_W(BANK_W)
  ) u_report (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .col_i       (is_col),
    .idx_i       (idx),
    .rank_i      (rank_i),
    .bank_i      (bank_i),
    .open_vec_i  (open_vec),
    .age_flat_i  (age_flat),
    .lim_i       (lim),
    .viol_o      (viol_o),
    .viol_rank_o (viol_rank_o),
    .viol_bank_o (viol_bank_o),
    .viol_dist_o (viol_dist_o)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_int_n |=> !viol_o);

  assert_ignored_code_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_i > 3'd4) |=> ($stable(open_vec) && !viol_o));

endmodule

// File: tb/test_act_col_checker.sv
`timescale 1ns/1ps
module test_act_col_checker;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] cmd;
  logic [0:0] rank;
  logic [2:0] bank;
  logic [5:0] trcd, al;
  logic       viol;
  logic [0:0] vrank;
  logic [2:0] vbank;
  logic [6:0] vdist;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  bit open_m [2][8];
  int act_m  [2][8];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  act_col_checker i_act_col_checker (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .rank_i(rank), .bank_i(bank),
    .trcd_i(trcd), .al_i(al), .viol_o(viol), .viol_rank_o(vrank),
    .viol_bank_o(vbank), .viol_dist_o(vdist)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    cmd = 3'd0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive one command at a falling edge, judge the result one cycle later.
  task automatic do_cmd(input int c, input int r, input int b, input string req);
    int lim, d;
    bit ev;
    cmd  = 3'(c);
    rank = 1'(r);
    bank = 3'(b);
    lim  = (int'(trcd) > int'(al)) ? int'(trcd) - int'(al) : 0;
    ev = 1'b0;
    d  = 0;
    if ((c == 2 || c == 3) && open_m[r][b]) begin
      d = cyc - act_m[r][b];
      if (d > 127) d = 127;
      ev = (d < lim);
    end
    if (c == 1) begin open_m[r][b] = 1'b1; act_m[r][b] = cyc; end
    if (c == 4) open_m[r][b] = 1'b0;
    @(negedge clk);
    chk(viol == ev, req, int'(viol), int'(ev));
    if (ev) begin
      chk(vrank == 1'(r), "R7 rank", int'(vrank), r);
      chk(vbank == 3'(b), "R7 bank", int'(vbank), b);
      chk(int'(vdist) == d, "R7 dist", int'(vdist), d);
    end
  endtask

  task automatic set_cfg(input int t, input int a);
    trcd = 6'(t);
    al   = 6'(a);
    idle(3);
  endtask

  initial begin
    #800000;
    nerr++;
    nchk++;
    $display("FAIL R3 watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int tl[4];
    int al_l[4];
    tl   = '{0, 4, 7, 12};
    al_l = '{0, 3, 7, 15};
    rst_n = 1'b0;
    cmd = 3'd0; rank = '0; bank = '0; trcd = 6'd8; al = 6'd0;
    for (int r = 0; r < 2; r++)
      for (int b = 0; b < 8; b++) begin open_m[r][b] = 1'b0; act_m[r][b] = 0; end
    repeat (3) @(negedge clk);
    chk(viol == 1'b0, "R1 during reset", int'(viol), 0);
    rst_n = 1'b1;
    idle(4);
    chk(viol == 1'b0, "R1 after reset", int'(viol), 0);

    // R1 / R8: nothing activated yet, so nothing is checked.
    do_cmd(2, 0, 0, "R1 read to closed bank");
    do_cmd(3, 1, 7, "R1 write to closed bank");

    // R3 R4 R5 R6: sweep configurations and distances.
    foreach (tl[ti]) foreach (al_l[ai]) begin
      set_cfg(tl[ti], al_l[ai]);
      for (int d = 1; d <= 14; d++) begin
        do_cmd(1, d % 2, d % 8, "R9 activate");
        idle(d - 1);
        do_cmd((d % 2 == 0) ? 2 : 3, d % 2, d % 8, "R3 R4 R5 R6 column distance");
        do_cmd(4, d % 2, d % 8, "R8 precharge");
      end
    end

    set_cfg(10, 2);
    // R8: precharge closes the bank before a too-early read.
    do_cmd(1, 0, 3, "R8 activate");
    do_cmd(4, 0, 3, "R8 precharge");
    do_cmd(2, 0, 3, "R8 read after close");

    // R2: unused codes neither close nor check.
    do_cmd(1, 1, 2, "R2 activate");
    do_cmd(5, 1, 2, "R2 code 5 ignored");
    do_cmd(7, 1, 2, "R2 code 7 ignored");
    do_cmd(2, 1, 2, "R2 bank still open");

    // R9: interleaved activates on other banks keep their own distances.
    do_cmd(1, 0, 5, "R9 activate a");
    do_cmd(1, 1, 5, "R9 activate b");
    idle(3);
    do_cmd(1, 0, 6, "R9 activate c");
    do_cmd(3, 0, 5, "R9 write a");
    do_cmd(2, 1, 5, "R9 read b");
    do_cmd(2, 0, 6, "R9 read c");
    idle(4);
    do_cmd(2, 0, 5, "R4 read a late");

    // R11 and R10: saturate, then re-arm in the same bank.
    set_cfg(63, 0);
    do_cmd(1, 1, 4, "R11 activate");
    idle(200);
    do_cmd(2, 1, 4, "R11 saturated read");
    do_cmd(1, 1, 4, "R10 reactivate");
    idle(1);
    do_cmd(2, 1, 4, "R10 read after rearm");
    do_cmd(1, 1, 4, "R10 reactivate again");
    do_cmd(3, 1, 4, "R10 back to back");

    idle(2);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule